// File: doc/BRIEF.md
# CAN Transmit Queue with Priority Slot

This block holds outgoing CAN messages until a bus transmit engine is ready for them. A host writes messages into one of two stores: an ordered queue with room for many complete messages, or a single urgent slot. Each message is an opaque word that carries the identifier, length code and payload. The block does not look inside it.

The transmit engine and the block share a simple handshake. While the engine is idle, the block offers the next message and marks whether it came from the urgent slot. The engine takes the message with an accept pulse. Later it reports with a done pulse that the frame has left the wire. A message in the urgent slot always goes ahead of anything in the queue. It does so only at a frame boundary, so a frame already handed over is never cut short.

The urgent slot is freed as soon as its message is taken. A queue entry is released only when its frame is reported done. The block also reports queue occupancy, full, empty and urgent-pending status. It keeps a sticky flag for writes that were dropped.

Top module: `can_tx_queue`

## Requirements
- R1: After a synchronous reset, both stores are empty. The occupancy count is 0, empty is 1, full is 0, urgent-pending is 0, the overflow flag is 0 and no request is offered.
- R2: When the urgent slot holds a message and the engine is idle, that message is offered with `txFromHp` = 1, ahead of every queued message. The slot reads empty in the cycle after the engine accepts it.
- R3: Queued messages are offered in the order they were written. An entry leaves the queue, and the count drops by one, in the cycle after `txDone` is pulsed for the frame it supplied.
- R4: Between an accept and the matching `txDone`, no request is offered, even if the urgent slot is loaded in that time. The urgent message is offered in the first cycle after the frame completes.
- R5: The queue holds `DEPTH` (default 64) messages. The count runs from 0 to `DEPTH`, and full is 1 exactly when the count equals `DEPTH`.
- R6: A write to the queue while it is full, or to the urgent slot while it is occupied, is dropped. The stored contents are unchanged and the overflow flag is set. The flag stays set until `ovfClear` is pulsed. A new drop in the same cycle as a clear keeps the flag set.
- R7: With the engine idle and both stores empty, `txReq` is 0. A message written in that state is offered, with its data on `txData`, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | Host write strobe |
| wrHigh | input | 1 | 1 selects the urgent slot, 0 the queue |
| wrData | input | MSG_W | Message word to store |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| txReq | output | 1 | A message is offered to the idle engine |
| txData | output | MSG_W | Offered message word |
| txFromHp | output | 1 | Offered message comes from the urgent slot |
| txAccept | input | 1 | Engine takes the offered message |
| txDone | input | 1 | Engine reports the current frame finished |
| fifoCount | output | $clog2(DEPTH+1) | Queue occupancy |
| fifoFull | output | 1 | Queue holds DEPTH messages |
| fifoEmpty | output | 1 | Queue holds no message |
| hpPending | output | 1 | Urgent slot occupied |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The queue is filled to its full depth with arithmetically distinct words and then drained completely. This separates correct ordering and count stepping from pointer-wrap and off-by-one faults. Writes to a full queue and to an occupied urgent slot check that dropped data never appears and that the flag is sticky and clearable. An urgent message loaded before a handover and another loaded during a frame in flight show that priority is applied at boundaries and never by interruption. Idle writes into empty stores pin the one-cycle start latency.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;
  typedef struct packed {
    logic push;    // store host word at queue tail
    logic pop;     // release queue head
    logic hpLoad;  // fill urgent slot
    logic hpTake;  // urgent slot handed to engine
  } txqStrobe_t;
endpackage

// File: rtl/can_txq_dpath.sv
module can_txq_dpath
  import can_txq_pkg::*;
#(
  parameter int MSG_W = 32,
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  txqStrobe_t       st,
  input  logic [MSG_W-1:0] wrData,
  output logic [MSG_W-1:0] txData,
  output logic [CNT_W-1:0] fifoCount,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             hpValid
);
  logic [MSG_W-1:0] mem [DEPTH];
  logic [MSG_W-1:0] hpWord;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (st.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (st.push) wrPtr <= nextPtr(wrPtr);
      if (st.pop)  rdPtr <= nextPtr(rdPtr);
      case ({st.push, st.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpValid <= 1'b0;
      hpWord  <= '0;
    end else if (st.hpLoad) begin
      hpValid <= 1'b1;
      hpWord  <= wrData;
    end else if (st.hpTake) begin
      hpValid <= 1'b0;
    end
  end

  assign fifoCount = count;
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign txData    = hpValid ? hpWord : mem[rdPtr];

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
    st.push && !st.pop |=> count == $past(count) + 1'b1);
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    st.pop && !st.push |=> count == $past(count) - 1'b1);
  a_r2_take_frees: assert property (@(posedge clk) disable iff (rst)
    st.hpTake |=> !hpValid);
endmodule

// File: rtl/can_txq_ctrl.sv
module can_txq_ctrl
  import can_txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrValid,
  input  logic       wrHigh,
  input  logic       ovfClear,
  input  logic       txAccept,
  input  logic       txDone,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  input  logic       hpValid,
  output logic       txReq,
  output logic       txFromHp,
  output logic       overflow,
  output txqStrobe_t st
);
  logic busy, curFromHp, accept, dropWr;

  assign txReq    = !busy && (hpValid || !fifoEmpty);
  assign txFromHp = hpValid;
  assign accept   = txReq && txAccept;
  assign dropWr   = wrValid && (wrHigh ? hpValid : fifoFull);

  always_comb begin
    st.push   = wrValid && !wrHigh && !fifoFull;
    st.hpLoad = wrValid && wrHigh && !hpValid;
    st.hpTake = accept && hpValid;
    st.pop    = busy && txDone && !curFromHp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      curFromHp <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (accept) begin
        busy      <= 1'b1;
        curFromHp <= hpValid;
      end else if (busy && txDone) begin
        busy <= 1'b0;
      end
      if (dropWr)        overflow <= 1'b1;
      else if (ovfClear) overflow <= 1'b0;
    end
  end

  a_r4_no_abort: assert property (@(posedge clk) disable iff (rst)
    busy && !txDone |=> busy && !txReq);
  a_r3_pop_on_done: assert property (@(posedge clk) disable iff (rst)
    st.pop |-> txDone && !fifoEmpty);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow && !ovfClear |=> overflow);
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (rst)
    dropWr |=> overflow);
endmodule

// File: rtl/can_tx_queue.sv
module can_tx_queue
  import can_txq_pkg::*;
#(
  parameter int MSG_W = 32,
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrValid,
  input  logic             wrHigh,
  input  logic [MSG_W-1:0] wrData,
  input  logic             ovfClear,
  output logic             txReq,
  output logic [MSG_W-1:0] txData,
  output logic             txFromHp,
  input  logic             txAccept,
  input  logic             txDone,
  output logic [CNT_W-1:0] fifoCount,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             hpPending,
  output logic             overflow
);
  txqStrobe_t st;
  logic hpValid;

  can_txq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrHigh(wrHigh),
    .ovfClear(ovfClear), .txAccept(txAccept), .txDone(txDone),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .hpValid(hpValid),
    .txReq(txReq), .txFromHp(txFromHp), .overflow(overflow), .st(st)
  );

  can_txq_dpath #(.MSG_W(MSG_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst(rst), .st(st), .wrData(wrData), .txData(txData),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .hpValid(hpValid)
  );

  assign hpPending = hpValid;

  a_r7_idle_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    fifoEmpty && !hpPending |-> !txReq);
endmodule

// File: tb/can_tx_queue_tb.sv
module can_tx_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MSG_W = 16;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic wrValid = 0, wrHigh = 0, ovfClear = 0, txAccept = 0, txDone = 0;
  logic [MSG_W-1:0] wrData = '0;
  logic txReq, txFromHp, fifoFull, fifoEmpty, hpPending, overflow;
  logic [MSG_W-1:0] txData;
  logic [CNT_W-1:0] fifoCount;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_tx_queue #(.MSG_W(MSG_W), .DEPTH(DEPTH)) u_dut (.*);

  function automatic logic [MSG_W-1:0] qWord(input int i);
    return MSG_W'(i * 37 + 5);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic high, input logic [MSG_W-1:0] d);
    wrValid = 1; wrHigh = high; wrData = d;
    tick();
    wrValid = 0; wrHigh = 0;
  endtask

  task automatic sendOne(input string req, input logic [MSG_W-1:0] expData, input logic expHp);
    chk(req, "txReq", txReq, 1);
    chk(req, "txData", txData, expData);
    chk(req, "txFromHp", txFromHp, expHp);
    txAccept = 1;
    tick();
    txAccept = 0;
    chk("R4", "no req while busy", txReq, 0);
    if (expHp) chk("R2", "slot freed on take", hpPending, 0);
    txDone = 1;
    tick();
    txDone = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); rst = 0;
    // R1 reset state
    chk("R1", "count", fifoCount, 0);
    chk("R1", "empty", fifoEmpty, 1);
    chk("R1", "full", fifoFull, 0);
    chk("R1", "hpPending", hpPending, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "txReq", txReq, 0);
    tick();
    chk("R7", "idle empty no req", txReq, 0);

    // R7 idle write starts next cycle
    hostWrite(0, 16'h1234);
    chk("R7", "req after write", txReq, 1);
    chk("R7", "data after write", txData, 16'h1234);
    chk("R3", "count one", fifoCount, 1);
    sendOne("R3", 16'h1234, 0);
    chk("R3", "popped after done", fifoCount, 0);
    chk("R7", "idle urgent", txReq, 0);
    hostWrite(1, 16'h0BEE);
    chk("R7", "urgent req next cycle", txReq, 1);
    sendOne("R2", 16'h0BEE, 1);

    // R5 fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      hostWrite(0, qWord(i));
      chk("R5", "count fill", fifoCount, i + 1);
      chk("R5", "full flag", fifoFull, (i + 1 == DEPTH));
      chk("R3", "head stays first", txData, qWord(0));
    end
    // R6 overflow on full queue
    hostWrite(0, 16'hFFFF);
    chk("R6", "count unchanged", fifoCount, DEPTH);
    chk("R6", "overflow set", overflow, 1);
    tick();
    chk("R6", "overflow sticky", overflow, 1);
    ovfClear = 1; tick(); ovfClear = 0;
    chk("R6", "overflow cleared", overflow, 0);

    // R2 urgent ahead of full queue; second urgent dropped
    hostWrite(1, 16'hA5A5);
    chk("R2", "hpPending", hpPending, 1);
    hostWrite(1, 16'h5A5A);
    chk("R6", "urgent drop flag", overflow, 1);
    sendOne("R2", 16'hA5A5, 1);
    chk("R2", "queue untouched", fifoCount, DEPTH);
    // R6 clear with simultaneous drop keeps flag
    wrValid = 1; wrHigh = 0; wrData = 16'hEEEE; ovfClear = 1;
    tick();
    wrValid = 0; ovfClear = 0;
    chk("R6", "set wins over clear", overflow, 1);
    ovfClear = 1; tick(); ovfClear = 0;

    // R4 urgent arriving mid-frame waits for boundary
    chk("R4", "req head", txData, qWord(0));
    txAccept = 1; tick(); txAccept = 0;
    hostWrite(1, 16'hC0DE);
    chk("R4", "busy ignores urgent", txReq, 0);
    tick();
    chk("R4", "still busy", txReq, 0);
    txDone = 1; tick(); txDone = 0;
    chk("R4", "count after frame", fifoCount, DEPTH - 1);
    sendOne("R4", 16'hC0DE, 1);
    chk("R4", "queue kept after urgent", fifoCount, DEPTH - 1);

    // R3 drain order
    for (int i = 1; i < DEPTH; i++) begin
      sendOne("R3", qWord(i), 0);
      chk("R3", "count drain", fifoCount, DEPTH - 1 - i);
    end
    chk("R5", "empty at end", fifoEmpty, 1);
    chk("R7", "no req at end", txReq, 0);
    chk("R6", "overflow clear", overflow, 0);

    // R1 reset clears loaded state
    hostWrite(0, 16'h0001);
    hostWrite(1, 16'h0002);
    rst = 1; tick(); rst = 0;
    chk("R1", "count after reset", fifoCount, 0);
    chk("R1", "hp after reset", hpPending, 0);
    chk("R1", "req after reset", txReq, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule